// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host and an asynchronous EDO DRAM holding 256K bytes. A host request carries an 18-bit byte address, a write flag and a data byte. The controller turns it into a strobe sequence on a shared nine-bit address bus. The row part goes out first and is latched by the row strobe falling. The column part follows and is latched by the column strobe falling. Every minimum pulse width and gap is set by a parameter that counts controller clocks.

After an access the row stays open. A later request to the same row then needs only a fresh column cycle and skips the row-strobe overhead. The controller closes the row and precharges before it opens another row in three cases: a request for a different row, a request from an external refresh arbiter, and a row that has been open close to its maximum time. Reads are sampled after the column strobe has risen again, because EDO parts keep driving the output once the column strobe is high. Each accepted request gets one response pulse, which also flags whether the access hit the open row.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row address (request bits 17:9) is on `dram_addr` when `dram_ras_n` falls, and the column address (bits 8:0) is on `dram_addr` when `dram_cas_n` falls.
- R2: `dram_ras_n` stays low for at least T_RAS clocks once it falls, and stays high for at least T_RP clocks before it falls again.
- R3: `dram_cas_n` falls no earlier than T_RCD clocks after `dram_ras_n` falls.
- R4: `dram_cas_n` goes low only while `dram_ras_n` is low, stays low for exactly T_CAS clocks, and stays high for at least T_CP clocks between two column cycles of one row.
- R5: A write drives `dram_we_n` low at least one clock before `dram_cas_n` falls and keeps it low while `dram_cas_n` is low. `dram_dq_oe` is high and `dram_oe_n` is high when the column strobe falls, and `dram_dq_oe` is never high while `dram_we_n` is high.
- R6: A read keeps `dram_we_n` high and holds `dram_oe_n` low through the column cycle. The returned byte is the one the DRAM drove at the column strobe fall, sampled after `dram_cas_n` has risen.
- R7: A request to the row that is already open is served with no row strobe activity and reports `rsp_page_hit` = 1. The first access after the row was closed reports 0.
- R8: A request for another row closes the open row, precharges it, and opens the new row before the column cycle.
- R9: A one-clock pulse on `row_close_req` while a row is open makes `dram_ras_n` rise once T_RAS is met, so the next access is a miss.
- R10: With T_RAS_MAX nonzero, an idle open row is closed before `dram_ras_n` has been low for T_RAS_MAX clocks.
- R11: After reset all strobes are high, `req_ready` is 1 and `rsp_valid` is 0. Each accepted request produces exactly one single-clock `rsp_valid` pulse, and the pulses come in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_addr | input | 18 | Byte address: row in 17:9, column in 8:0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| row_close_req | input | 1 | Refresh grant: close the open row |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid on reads |
| rsp_page_hit | output | 1 | Access was served from the already open row |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data driven to the DRAM on writes |
| dram_dq_oe | output | 1 | Controller drives the data bus |
| dram_dq_in | input | 8 | Data bus as seen from the DRAM |

## Verification
A behavioural EDO DRAM in the bench latches row and column on the strobe edges, stores writes, and drives read data from the column fall until the next fall. Between those points it puts a junk byte on the bus whenever output enable is high, so a read sampled at the wrong moment returns the wrong byte. Write runs spread over one row (columns 0, 511 and in between), reads in shuffled order, and alternating read/write hits exercise the page path. Row changes, a refresh-grant pulse and a long idle gap each have to produce a miss flag and a fresh row strobe, which tells apart the three ways a row can close. The model also times every strobe edge against the clock-count minimums.

// File: rtl/edo_pkg.sv
package edo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // row strobe high, precharge complete
      ST_RCD,    // row strobe low, row on bus
      ST_CSET,   // column on bus, write enable settling
      ST_CASL,   // column strobe low
      ST_CASH,   // column strobe high, read data held
      ST_OPEN,   // row open, waiting
      ST_PRE     // row strobe high, precharging
   } edo_state_t;
endpackage

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (load)      cnt <= load_val;
      else if (cnt != '0) cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_age.sv
module edo_ras_age #(
   parameter int T_RAS    = 5,
   parameter int CLOSE_AT = 0   // 0 disables the forced close
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_low,
   output logic min_met,
   output logic max_hit
);
   localparam int LIMIT = (CLOSE_AT > T_RAS) ? CLOSE_AT : T_RAS;
   localparam int AW    = $clog2(LIMIT + 1);

   logic [AW-1:0] age;

   always_ff @(posedge clk) begin
      if (!rst_n || !ras_low)      age <= '0;
      else if (age != AW'(LIMIT))  age <= age + 1'b1;
   end

   assign min_met = (age >= AW'(T_RAS - 1));

   generate
      if (CLOSE_AT == 0) begin : g_no_limit
         assign max_hit = 1'b0;
      end else begin : g_limit
         assign max_hit = (age >= AW'(CLOSE_AT));
      end
   endgenerate
endmodule

// File: rtl/edo_req_latch.sv
module edo_req_latch #(
   parameter int ROW_W  = 9,
   parameter int COL_W  = 9,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    capture,
   input  logic [ROW_W+COL_W-1:0]  addr,
   input  logic                    write,
   input  logic [DATA_W-1:0]       wdata,
   output logic [ROW_W-1:0]        row,
   output logic [COL_W-1:0]        col,
   output logic                    wr,
   output logic [DATA_W-1:0]       data,
   output logic                    same_row
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row  <= '0;
         col  <= '0;
         wr   <= 1'b0;
         data <= '0;
      end else if (capture) begin
         row  <= addr[ROW_W+COL_W-1:COL_W];
         col  <= addr[COL_W-1:0];
         wr   <= write;
         data <= wdata;
      end
   end

   assign same_row = (addr[ROW_W+COL_W-1:COL_W] == row);
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
   import edo_pkg::*;
#(
   parameter int ADDR_W    = 18,
   parameter int ROW_W     = 9,
   parameter int DATA_W    = 8,
   parameter int T_RCD     = 2,
   parameter int T_RAS     = 5,
   parameter int T_RP      = 3,
   parameter int T_CAS     = 2,
   parameter int T_CP      = 1,
   parameter int T_RAS_MAX = 200,
   localparam int COL_W    = ADDR_W - ROW_W,
   localparam int MUX_W    = (ROW_W >= COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              row_close_req,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_page_hit,
   output logic [MUX_W-1:0]  dram_addr,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   // Longest column cycle after the age check passes: CSET + CASL + CASH + OPEN.
   localparam int CYC_TAIL = T_CAS + T_CP + 2;
   localparam int CLOSE_AT = (T_RAS_MAX == 0) ? 0 : T_RAS_MAX - CYC_TAIL;
   localparam int T_MAX1   = (T_RCD > T_RAS) ? T_RCD : T_RAS;
   localparam int T_MAX2   = (T_RP > T_CAS) ? T_RP : T_CAS;
   localparam int T_MAX3   = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
   localparam int TW       = $clog2(((T_MAX3 > T_CP) ? T_MAX3 : T_CP) + 1);

   generate
      if (T_RCD < 1 || T_RAS < 1 || T_RP < 1 || T_CAS < 1 || T_CP < 1) begin : g_bad_timing
         $error("edo_page_ctrl: every timing count must be at least 1");
      end
      if (T_RAS_MAX != 0 && CLOSE_AT <= T_RAS) begin : g_bad_max
         $error("edo_page_ctrl: T_RAS_MAX too small for one column cycle");
      end
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_split
         $error("edo_page_ctrl: address split leaves an empty field");
      end
   endgenerate

   edo_state_t state, state_nx;

   logic              t_done, t_load;
   logic [TW-1:0]     t_val;
   logic              min_met, max_hit, ras_lo;
   logic              accept, row_hit, acc_hit, close_pend, close_need;
   logic [ROW_W-1:0]  acc_row;
   logic [COL_W-1:0]  acc_col;
   logic              acc_wr;
   logic [DATA_W-1:0] acc_wdata;

   assign ras_lo = (state != ST_IDLE) && (state != ST_PRE);

   edo_phase_timer #(.W(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
   );

   edo_ras_age #(.T_RAS(T_RAS), .CLOSE_AT(CLOSE_AT)) u_age (
      .clk(clk), .rst_n(rst_n), .ras_low(ras_lo), .min_met(min_met), .max_hit(max_hit)
   );

   edo_req_latch #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_req (
      .clk(clk), .rst_n(rst_n), .capture(accept), .addr(req_addr),
      .write(req_write), .wdata(req_wdata), .row(acc_row), .col(acc_col),
      .wr(acc_wr), .data(acc_wdata), .same_row(row_hit)
   );

   // Host handshake: idle always takes a request; an open row only takes hits.
   always_comb begin
      req_ready = 1'b0;
      if (state == ST_IDLE)
         req_ready = 1'b1;
      else if (state == ST_OPEN)
         req_ready = row_hit && !close_pend && !row_close_req && !max_hit;
   end
   assign accept     = req_valid && req_ready;
   assign close_need = close_pend || row_close_req || max_hit || (req_valid && !row_hit);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (accept) state_nx = ST_RCD;
         ST_RCD:  if (t_done) state_nx = ST_CSET;
         ST_CSET: state_nx = ST_CASL;
         ST_CASL: if (t_done) state_nx = ST_CASH;
         ST_CASH: if (t_done) state_nx = ST_OPEN;
         ST_OPEN: begin
            if (accept)                      state_nx = ST_CSET;
            else if (close_need && min_met)  state_nx = ST_PRE;
         end
         ST_PRE:  if (t_done) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   // Each timed phase lasts its count in clocks; the timer gets count-1 on entry.
   always_comb begin
      t_load = (state_nx != state);
      unique case (state_nx)
         ST_RCD:  t_val = TW'(T_RCD - 1);
         ST_CASL: t_val = TW'(T_CAS - 1);
         ST_CASH: t_val = TW'(T_CP - 1);
         ST_PRE:  t_val = TW'(T_RP - 1);
         default: t_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         acc_hit      <= 1'b0;
         close_pend   <= 1'b0;
         rsp_valid    <= 1'b0;
         rsp_rdata    <= '0;
         rsp_page_hit <= 1'b0;
      end else begin
         state <= state_nx;
         if (accept) acc_hit <= (state == ST_OPEN);
         if (!ras_lo || state_nx == ST_PRE) close_pend <= 1'b0;
         else if (row_close_req)            close_pend <= 1'b1;
         rsp_valid <= (state == ST_CASH) && t_done;
         if ((state == ST_CASH) && t_done) begin
            rsp_rdata    <= acc_wr ? '0 : dram_dq_in;
            rsp_page_hit <= acc_hit;
         end
      end
   end

   assign dram_ras_n  = !ras_lo;
   assign dram_cas_n  = (state != ST_CASL);
   assign dram_addr   = (state == ST_RCD) ? MUX_W'(acc_row) : MUX_W'(acc_col);
   assign dram_we_n   = !(acc_wr && (state == ST_CSET || state == ST_CASL));
   assign dram_dq_oe  = acc_wr && (state == ST_CSET || state == ST_CASL);
   assign dram_dq_out = acc_wdata;
   assign dram_oe_n   = !(!acc_wr && (state == ST_CASL || state == ST_CASH));
endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
   parameter int T_RCD     = 2,
   parameter int T_RAS     = 5,
   parameter int T_RP      = 3,
   parameter int T_RAS_MAX = 200
) (
   input logic clk,
   input logic rst_n,
   input logic dram_ras_n,
   input logic dram_cas_n,
   input logic dram_we_n,
   input logic dram_oe_n,
   input logic dram_dq_oe,
   input logic rsp_valid
);
   logic [15:0] lo_cnt, hi_cnt;
   logic        ras_q, cas_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= 16'(T_RP);
         ras_q  <= 1'b1;
         cas_q  <= 1'b1;
      end else begin
         ras_q <= dram_ras_n;
         cas_q <= dram_cas_n;
         if (dram_ras_n) begin
            lo_cnt <= '0;
            if (hi_cnt != 16'hffff) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            hi_cnt <= '0;
            if (lo_cnt != 16'hffff) lo_cnt <= lo_cnt + 1'b1;
         end
         // R2: low and high widths of the row strobe
         if (dram_ras_n && !ras_q)
            p_ras_low_min_r2: assert (lo_cnt >= 16'(T_RAS));
         if (!dram_ras_n && ras_q)
            p_ras_precharge_r2: assert (hi_cnt >= 16'(T_RP));
         // R3: row-to-column delay
         if (!dram_cas_n && cas_q)
            p_rcd_min_r3: assert (lo_cnt >= 16'(T_RCD));
         // R10: longest time the row strobe stays low
         if (T_RAS_MAX != 0)
            p_ras_low_max_r10: assert (lo_cnt <= 16'(T_RAS_MAX));
      end
   end

   p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n |-> !dram_ras_n);

   p_early_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_cas_n) && !dram_we_n) |-> !$past(dram_we_n));

   p_drive_only_writing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> (!dram_we_n && dram_oe_n));

   p_rsp_one_clock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
   .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
   .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe),
   .rsp_valid(rsp_valid)
);

// File: tb/tb_edo_page_ctrl.sv
module tb_edo_page_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int T_RCD = 2, T_RAS = 5, T_RP = 3, T_CAS = 2, T_CP = 1, T_RAS_MAX = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, row_close_req = 1'b0;
   logic [17:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rsp_valid, rsp_page_hit;
   logic [7:0]  rsp_rdata, dram_dq_out;
   logic [8:0]  dram_addr;
   logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [7:0]  dram_dq_in = 8'hA5;

   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edo_page_ctrl #(.T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_CAS(T_CAS),
                   .T_CP(T_CP), .T_RAS_MAX(T_RAS_MAX)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .row_close_req(row_close_req), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .rsp_page_hit(rsp_page_hit), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
      .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
      .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] blank_val(input logic [17:0] a);
      return 8'(a ^ (a >> 9) ^ 18'h3C);
   endfunction

   // ---------------- behavioural EDO DRAM, sampled on the falling clock ------------
   logic [7:0]  mem [int];
   logic [8:0]  m_row;
   logic        pr = 1'b1, pc = 1'b1, pw = 1'b1;
   int          lo_n = 0, hi_n = 100, cas_lo_n = 0, cas_hi_n = 100;
   logic [17:0] addr_q [$];

   always @(negedge clk) begin
      if (rst_n) begin
         if (pr && !dram_ras_n) begin
            m_row = dram_addr;
            chk(hi_n >= T_RP, "R2 precharge", hi_n, T_RP);
            cas_hi_n = 100;
         end
         if (!pr && dram_ras_n)
            chk(lo_n >= T_RAS, "R2 ras low", lo_n, T_RAS);
         if (pc && !dram_cas_n) begin
            logic [17:0] a;
            a = {m_row, dram_addr};
            chk(!dram_ras_n, "R4 cas in ras", dram_ras_n, 0);
            chk(lo_n >= T_RCD, "R3 ras to cas", lo_n, T_RCD);
            chk(cas_hi_n >= T_CP, "R4 cas high", cas_hi_n, T_CP);
            if (addr_q.size() > 0) begin
               logic [17:0] ea;
               ea = addr_q.pop_front();
               chk(a == ea, "R1 address split", a, ea);
            end else chk(1'b0, "R1 unexpected column", a, 0);
            if (!dram_we_n) begin
               chk(!pw, "R5 early we", pw, 0);
               chk(dram_dq_oe && dram_oe_n, "R5 bus drive", dram_dq_oe, 1);
               mem[int'(a)] = dram_dq_out;
            end else begin
               chk(!dram_oe_n && !dram_dq_oe, "R6 read oe", dram_oe_n, 0);
               dram_dq_in <= mem.exists(int'(a)) ? mem[int'(a)] : blank_val(a);
            end
         end else if (dram_oe_n) dram_dq_in <= 8'hA5;
         if (!pc && dram_cas_n)
            chk(cas_lo_n == T_CAS, "R4 cas low width", cas_lo_n, T_CAS);
         if (!dram_cas_n && !pw)
            chk(!dram_we_n, "R5 we held", dram_we_n, 0);
         if (dram_ras_n) begin lo_n = 0; hi_n++; end else begin hi_n = 0; lo_n++; end
         if (dram_cas_n) begin cas_lo_n = 0; cas_hi_n++; end else begin cas_hi_n = 0; cas_lo_n++; end
         pr = dram_ras_n; pc = dram_cas_n; pw = dram_we_n;
      end
   end

   // ---------------- scoreboard ---------------------------------------------------
   typedef struct packed { logic wr; logic [7:0] data; logic hit; } exp_t;
   exp_t        exp_q [$];
   logic [7:0]  shadow [int];
   logic        exp_open = 1'b0;
   logic [8:0]  exp_row = '0;

   task automatic issue(input logic [17:0] a, input logic wr, input logic [7:0] d);
      exp_t e;
      e.hit  = exp_open && (a[17:9] == exp_row);
      e.wr   = wr;
      e.data = wr ? 8'h00 : (shadow.exists(int'(a)) ? shadow[int'(a)] : blank_val(a));
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
      forever begin
         #1;
         if (req_ready) break;
         @(negedge clk);
      end
      addr_q.push_back(a);
      exp_q.push_back(e);
      @(posedge clk);
      if (wr) shadow[int'(a)] = d;
      exp_open = 1'b1; exp_row = a[17:9];
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R11 extra response", 1, 0);
         else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rsp_page_hit == e.hit, "R7 page hit flag", rsp_page_hit, e.hit);
            if (!e.wr) chk(rsp_rdata == e.data, "R6 read data", rsp_rdata, e.data);
         end
      end
   end

   task automatic drain();
      int guard = 0;
      while ((exp_q.size() != 0) && guard < 200) begin @(negedge clk); guard++; end
      chk(exp_q.size() == 0, "R11 all responses", exp_q.size(), 0);
   endtask

   // ---------------- stimulus ------------------------------------------------------
   logic finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R11 strobes idle", 0, 1);
      chk(req_ready == 1'b1, "R11 ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R11 no response", rsp_valid, 0);
      rst_n = 1'b1;

      // R5/R7: write run in one row, edge columns included
      issue({9'd5, 9'd3},   1'b1, 8'h11);
      issue({9'd5, 9'd511}, 1'b1, 8'h22);
      issue({9'd5, 9'd0},   1'b1, 8'h33);
      issue({9'd5, 9'd200}, 1'b1, 8'h44);
      // R6/R7: reads back in shuffled order, all hits
      issue({9'd5, 9'd0},   1'b0, 8'h00);
      issue({9'd5, 9'd511}, 1'b0, 8'h00);
      issue({9'd5, 9'd200}, 1'b0, 8'h00);
      issue({9'd5, 9'd3},   1'b0, 8'h00);
      issue({9'd5, 9'd77},  1'b0, 8'h00);
      // R8: other rows, unwritten and then alternating write/read
      issue({9'd511, 9'd9}, 1'b0, 8'h00);
      issue({9'd0, 9'd9},   1'b1, 8'h5C);
      issue({9'd0, 9'd9},   1'b0, 8'h00);
      issue({9'd5, 9'd3},   1'b0, 8'h00);
      for (int i = 0; i < 8; i++) begin
         issue({9'd0, 9'(i * 61)}, 1'b1, 8'(8'hC0 + i));
         issue({9'd0, 9'(i * 61)}, 1'b0, 8'h00);
      end
      drain();

      // R9: refresh grant closes the row
      @(negedge clk);
      row_close_req = 1'b1;
      @(negedge clk);
      row_close_req = 1'b0;
      repeat (T_RAS + 2) @(negedge clk);
      chk(dram_ras_n == 1'b1, "R9 row closed", dram_ras_n, 1);
      exp_open = 1'b0;
      issue({9'd0, 9'd61}, 1'b0, 8'h00);
      drain();

      // R10: long idle forces the row closed
      repeat (T_RAS_MAX + 20) @(negedge clk);
      chk(dram_ras_n == 1'b1, "R10 timed close", dram_ras_n, 1);
      exp_open = 1'b0;
      issue({9'd0, 9'd122}, 1'b0, 8'h00);
      issue({9'd0, 9'd183}, 1'b0, 8'h00);
      drain();
      repeat (5) @(negedge clk);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (200000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule